// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Global-Preserving Flush

This block is a small, fully associative cache of address translations. It maps the page number of a 32-bit linear address to the frame number of a 40-bit physical address. Each entry holds a valid bit, a global bit, a page-size code, the stored page number and the stored frame number. An entry can describe a small 4 KB page or a large page of 2 MB or 4 MB. A large entry compares only the page-number bits above its larger offset, and it passes the linear-address bits below that boundary straight into the physical address.

A lookup port answers in the same cycle with a hit and the physical address, or with a miss. A page walker writes new translations through the fill port. The fill goes to the lowest-numbered free entry. When every entry is occupied, it goes to the entry chosen by a round-robin pointer.

Two bulk flush inputs signal a reload of the directory base and a task switch. Either one removes every valid entry except those that are global. An entry counts as global only while its global bit and the global-page enable input are both 1. A separate single-page invalidate input removes the entries that cover a given address, global or not.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so each lookup reports a miss until a fill has completed.
- R2: A lookup that matches a 4 KB entry (size code 0) raises `lkp_hit` in the same cycle. `lkp_pa` is then the stored 28-bit frame followed by linear-address bits 11:0.
- R3: An entry with size code 1 (2 MB) compares only linear-address bits 31:21 and takes physical bits 20:0 from the linear address. An entry with size code 2 (4 MB) compares only bits 31:22 and takes physical bits 21:0 from the linear address. Code 3 behaves as code 0.
- R4: While `lkp_valid` is 1, exactly one of `lkp_hit` and `lkp_miss` is 1, and the miss is raised when no valid entry matches. While `lkp_valid` is 0, both are 0.
- R5: A fill writes the lowest-indexed invalid entry. If no entry is invalid, the fill writes the entry at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, only on fills that replace an entry.
- R6: With `glb_enable` at 1, a `dbase_reload` or `task_switch` pulse removes every entry whose global bit is 0 and keeps every entry whose global bit is 1.
- R7: With `glb_enable` at 0, a `dbase_reload` or `task_switch` pulse removes every entry, including those whose global bit is 1.
- R8: An `inval_valid` pulse removes every valid entry whose page covers `inval_la`, regardless of its global bit. All other entries stay valid.
- R9: A lookup in the same cycle as a bulk flush sees the state after the flush: it misses on entries that the flush removes and still hits on entries that the flush keeps.
- R10: A fill takes effect at the clock edge. A lookup of the filled page in the fill cycle misses, and the same lookup in the next cycle hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_la | input | 32 | Linear address to translate |
| lkp_hit | output | 1 | Lookup matched a valid entry |
| lkp_miss | output | 1 | Lookup found no valid entry |
| lkp_pa | output | 40 | Translated physical address (valid with hit) |
| fill_valid | input | 1 | Write a new translation |
| fill_la | input | 32 | Linear address whose page is being filled |
| fill_frame | input | 28 | Physical frame number for the fill |
| fill_size | input | 2 | Page-size code: 0 = 4 KB, 1 = 2 MB, 2 = 4 MB |
| fill_global | input | 1 | Global bit of the new entry |
| dbase_reload | input | 1 | Directory base reload, bulk flush |
| task_switch | input | 1 | Task switch, bulk flush |
| glb_enable | input | 1 | Global-page enable; 1 lets global entries survive a bulk flush |
| inval_valid | input | 1 | Single-page invalidate request |
| inval_la | input | 32 | Address whose covering entries are removed |

## Verification
A lookup and a bulk flush can arrive in the same cycle. The flush must act first, so the lookup sees only the surviving entries. The bench provokes this by raising `lkp_valid` together with `dbase_reload` or `task_switch`. In one case the lookup targets a non-global entry, which must miss. In the other it targets a global entry while `glb_enable` is 1, which must still hit. Each outcome is compared with a model that applies the flush before answering. A fill paired with a lookup of the same page in one cycle is also checked: the lookup must miss in that cycle and hit in the next.

// File: rtl/xc_pkg.sv
package xc_pkg;

    localparam int LA_W     = 32;
    localparam int PA_W     = 40;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = LA_W - OFF_W;
    localparam int PFN_W    = PA_W - OFF_W;
    localparam int MID_BITS = 9;    // extra offset bits of a 2 MB page
    localparam int BIG_BITS = 10;   // extra offset bits of a 4 MB page

    typedef enum logic [1:0] {
        PG_SMALL = 2'd0,
        PG_MID   = 2'd1,
        PG_BIG   = 2'd2,
        PG_RSVD  = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic             glb;
        pg_size_e         sz;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } xc_entry_t;

    // Page-number bits that take part in the tag compare for a size code
    function automatic logic [VPN_W-1:0] vpn_mask(input pg_size_e sz);
        logic [VPN_W-1:0] m;
        m = '1;
        case (sz)
            PG_MID:  m[MID_BITS-1:0] = '0;
            PG_BIG:  m[BIG_BITS-1:0] = '0;
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic vpn_hit(input logic [VPN_W-1:0] stored,
                                     input logic [VPN_W-1:0] probe,
                                     input pg_size_e         sz);
        return ((stored ^ probe) & vpn_mask(sz)) == '0;
    endfunction

    // Frame bits above the page offset, linear bits inside it
    function automatic logic [PA_W-1:0] form_pa(input logic [PFN_W-1:0] pfn,
                                                input logic [LA_W-1:0]  la,
                                                input pg_size_e         sz);
        logic [PFN_W-1:0] keep;
        logic [PFN_W-1:0] from_la;
        keep    = {{(PFN_W-VPN_W){1'b1}}, vpn_mask(sz)};
        from_la = {{(PFN_W-VPN_W){1'b0}}, la[LA_W-1:OFF_W]};
        return {(pfn & keep) | (from_la & ~keep), la[OFF_W-1:0]};
    endfunction

endpackage

// File: rtl/xc_match.sv
module xc_match
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  xc_entry_t [ENTRIES-1:0] ents,
    input  logic [ENTRIES-1:0]      vld,
    input  logic [VPN_W-1:0]        probe_vpn,
    output logic [ENTRIES-1:0]      hit_o
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_o[i] = vld[i] && vpn_hit(ents[i].vpn, probe_vpn, ents[i].sz);
    end

endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] vld_view,
    input  logic               fill_en,
    output logic [IDX_W-1:0]   slot_o
);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    // Lowest-indexed free entry: scan from the top so the lowest wins
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_view[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign slot_o = free_any ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill_en && !free_any) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xc_store.sv
module xc_store
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ENTRIES-1:0]      drop,
    input  logic                    fill_en,
    input  logic [IDX_W-1:0]        fill_slot,
    input  xc_entry_t               fill_ent,
    output logic [ENTRIES-1:0]      vld_o,
    output xc_entry_t [ENTRIES-1:0] ents_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= '0;
        end else begin
            vld_o <= vld_o & ~drop;
            if (fill_en) begin
                vld_o[fill_slot] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            ents_o[fill_slot] <= fill_ent;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lkp_valid,
    input  logic [LA_W-1:0]  lkp_la,
    output logic             lkp_hit,
    output logic             lkp_miss,
    output logic [PA_W-1:0]  lkp_pa,
    input  logic             fill_valid,
    input  logic [LA_W-1:0]  fill_la,
    input  logic [PFN_W-1:0] fill_frame,
    input  logic [1:0]       fill_size,
    input  logic             fill_global,
    input  logic             dbase_reload,
    input  logic             task_switch,
    input  logic             glb_enable,
    input  logic             inval_valid,
    input  logic [LA_W-1:0]  inval_la
);

    logic [ENTRIES-1:0]      vld_q;
    xc_entry_t [ENTRIES-1:0] ents_q;
    logic [ENTRIES-1:0]      glb_vec;
    logic [ENTRIES-1:0]      kill;
    logic [ENTRIES-1:0]      vld_lkp;
    logic [ENTRIES-1:0]      lkp_hits;
    logic [ENTRIES-1:0]      inv_hits;
    logic [ENTRIES-1:0]      drop;
    logic [ENTRIES-1:0]      vld_free;
    logic [IDX_W-1:0]        slot;
    logic                    bulk;
    xc_entry_t               new_ent;

    assign bulk = dbase_reload | task_switch;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
        assign glb_vec[i] = ents_q[i].glb;
        assign kill[i]    = bulk && !(ents_q[i].glb && glb_enable);
    end

    // The flush acts before the lookup in the same cycle
    assign vld_lkp  = vld_q & ~kill;
    assign drop     = kill | inv_hits;
    assign vld_free = vld_q & ~drop;

    xc_match #(.ENTRIES(ENTRIES)) u_lkp_match (
        .ents      (ents_q),
        .vld       (vld_lkp),
        .probe_vpn (lkp_la[LA_W-1:OFF_W]),
        .hit_o     (lkp_hits)
    );

    xc_match #(.ENTRIES(ENTRIES)) u_inv_match (
        .ents      (ents_q),
        .vld       (vld_q & {ENTRIES{inval_valid}}),
        .probe_vpn (inval_la[LA_W-1:OFF_W]),
        .hit_o     (inv_hits)
    );

    xc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .vld_view (vld_free),
        .fill_en  (fill_valid),
        .slot_o   (slot)
    );

    always_comb begin
        new_ent.glb = fill_global;
        new_ent.sz  = pg_size_e'(fill_size);
        new_ent.vpn = fill_la[LA_W-1:OFF_W];
        new_ent.pfn = fill_frame;
    end

    xc_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .drop      (drop),
        .fill_en   (fill_valid),
        .fill_slot (slot),
        .fill_ent  (new_ent),
        .vld_o     (vld_q),
        .ents_o    (ents_q)
    );

    always_comb begin
        lkp_pa = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lkp_hits[i]) begin
                lkp_pa = lkp_pa | form_pa(ents_q[i].pfn, lkp_la, ents_q[i].sz);
            end
        end
    end

    assign lkp_hit  = lkp_valid && (lkp_hits != '0);
    assign lkp_miss = lkp_valid && (lkp_hits == '0);

endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               lkp_valid,
    input logic               lkp_hit,
    input logic               lkp_miss,
    input logic               dbase_reload,
    input logic               task_switch,
    input logic               glb_enable,
    input logic               fill_valid,
    input logic               inval_valid,
    input logic [ENTRIES-1:0] vld,
    input logic [ENTRIES-1:0] glb_bits
);

    a_r1_reset_empty: assert property (@(posedge clk) rst |=> vld == '0)
        else $error("R1: entries valid after reset");

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lkp_valid |-> (!lkp_hit && !lkp_miss))
        else $error("R4: hit or miss without lookup");

    a_r4_one_answer: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |-> (lkp_hit != lkp_miss))
        else $error("R4: lookup answer not exclusive");

    a_r9_flush_first: assert property (@(posedge clk) disable iff (rst)
        ((dbase_reload || task_switch) && !glb_enable && lkp_valid) |-> !lkp_hit)
        else $error("R9: lookup hit during full flush");

    a_r10_fill_lands: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> vld != '0)
        else $error("R10: fill left no valid entry");

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        a_r6_global_kept: assert property (@(posedge clk) disable iff (rst)
            ((dbase_reload || task_switch) && glb_enable && vld[i] && glb_bits[i]
             && !inval_valid && !fill_valid) |=> vld[i])
            else $error("R6: global entry lost on flush");

        a_r6_local_dropped: assert property (@(posedge clk) disable iff (rst)
            ((dbase_reload || task_switch) && !glb_bits[i] && !fill_valid) |=> !vld[i])
            else $error("R6: local entry survived flush");

        a_r7_all_dropped: assert property (@(posedge clk) disable iff (rst)
            ((dbase_reload || task_switch) && !glb_enable && !fill_valid) |=> !vld[i])
            else $error("R7: entry survived flush with global pages off");
    end

endmodule

bind xlat_cache xc_checker #(.ENTRIES(ENTRIES)) u_xc_checker (
    .clk          (clk),
    .rst          (rst),
    .lkp_valid    (lkp_valid),
    .lkp_hit      (lkp_hit),
    .lkp_miss     (lkp_miss),
    .dbase_reload (dbase_reload),
    .task_switch  (task_switch),
    .glb_enable   (glb_enable),
    .fill_valid   (fill_valid),
    .inval_valid  (inval_valid),
    .vld          (vld_q),
    .glb_bits     (glb_vec)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_la = '0;
    logic        lkp_hit, lkp_miss;
    logic [39:0] lkp_pa;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_la = '0;
    logic [27:0] fill_frame = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_global = 1'b0;
    logic        dbase_reload = 1'b0;
    logic        task_switch = 1'b0;
    logic        glb_enable = 1'b1;
    logic        inval_valid = 1'b0;
    logic [31:0] inval_la = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    bit          m_vld [N];
    logic [19:0] m_vpn [N];
    logic [27:0] m_pfn [N];
    logic [1:0]  m_sz  [N];
    bit          m_g   [N];
    int          m_rr;

    always #4 clk = ~clk;

    xlat_cache #(.ENTRIES(N)) i_xlat_cache (
        .clk(clk), .rst(rst),
        .lkp_valid(lkp_valid), .lkp_la(lkp_la),
        .lkp_hit(lkp_hit), .lkp_miss(lkp_miss), .lkp_pa(lkp_pa),
        .fill_valid(fill_valid), .fill_la(fill_la), .fill_frame(fill_frame),
        .fill_size(fill_size), .fill_global(fill_global),
        .dbase_reload(dbase_reload), .task_switch(task_switch),
        .glb_enable(glb_enable),
        .inval_valid(inval_valid), .inval_la(inval_la)
    );

    function automatic int low_bits(input logic [1:0] sz);
        return (sz == 2'd1) ? 9 : (sz == 2'd2) ? 10 : 0;
    endfunction

    function automatic bit m_match(input int i, input logic [31:0] la);
        int lo;
        lo = low_bits(m_sz[i]);
        return m_vld[i] && ((m_vpn[i] >> lo) == (la[31:12] >> lo));
    endfunction

    task automatic m_flush();
        for (int i = 0; i < N; i++)
            if (!(m_g[i] && glb_enable)) m_vld[i] = 1'b0;
    endtask

    task automatic m_reset();
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_rr = 0;
    endtask

    // One clock cycle of fill / invalidate / flush, then the model update
    task automatic op(input bit f, input logic [31:0] fla, input logic [27:0] fpfn,
                      input logic [1:0] fsz, input bit fg,
                      input bit iv, input logic [31:0] ila,
                      input bit dr, input bit ts);
        int slot;
        fill_valid = f; fill_la = fla; fill_frame = fpfn; fill_size = fsz; fill_global = fg;
        inval_valid = iv; inval_la = ila; dbase_reload = dr; task_switch = ts;
        @(negedge clk);
        if (dr || ts) m_flush();
        if (iv) for (int i = 0; i < N; i++) if (m_match(i, ila)) m_vld[i] = 1'b0;
        if (f) begin
            slot = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_vld[slot] = 1'b1; m_vpn[slot] = fla[31:12]; m_pfn[slot] = fpfn;
            m_sz[slot] = fsz; m_g[slot] = fg;
        end
        fill_valid = 1'b0; inval_valid = 1'b0; dbase_reload = 1'b0; task_switch = 1'b0;
    endtask

    task automatic fill(input logic [31:0] la, input logic [27:0] pfn,
                        input logic [1:0] sz, input bit g);
        op(1'b1, la, pfn, sz, g, 1'b0, '0, 1'b0, 1'b0);
    endtask

    // Compare the current combinational answer with the model
    task automatic expect_lkp(input logic [31:0] la, input string req);
        bit          eh;
        logic [39:0] ep;
        int          lo;
        eh = 1'b0; ep = '0;
        for (int i = 0; i < N; i++) begin
            if (m_match(i, la)) begin
                eh = 1'b1;
                lo = low_bits(m_sz[i]) + 12;
                ep = {m_pfn[i], 12'h000};
                for (int k = 0; k < lo; k++) ep[k] = la[k];
            end
        end
        checks++;
        if (lkp_hit !== eh || lkp_miss !== !eh || (eh && lkp_pa !== ep)) begin
            fails++;
            $display("FAIL %s la=%h: hit=%b miss=%b pa=%h expected hit=%b miss=%b pa=%h",
                     req, la, lkp_hit, lkp_miss, lkp_pa, eh, !eh, ep);
        end
    endtask

    task automatic look(input logic [31:0] la, input bit want_hit, input string req);
        lkp_valid = 1'b1; lkp_la = la;
        #1;
        expect_lkp(la, req);
        checks++;
        if (lkp_hit !== want_hit) begin
            fails++;
            $display("FAIL %s la=%h: hit=%b expected %b", req, la, lkp_hit, want_hit);
        end
        lkp_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        checks++;
        if (lkp_hit !== 1'b0 || lkp_miss !== 1'b0) begin
            fails++;
            $display("FAIL R4 idle: hit=%b miss=%b expected 0 0", lkp_hit, lkp_miss);
        end
        look(32'h0000_0000, 1'b0, "R1");
        look(32'hFFFF_F123, 1'b0, "R1");
    endtask

    task automatic t_small();
        // R10: the lookup in the fill cycle misses
        fill_valid = 1'b1; fill_la = 32'h1234_5000; fill_frame = 28'hABC_DE01;
        fill_size = 2'd0; fill_global = 1'b0;
        look(32'h1234_5ABC, 1'b0, "R10");
        fill_valid = 1'b0;
        op(1'b1, 32'h1234_5000, 28'hABC_DE01, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        look(32'h1234_5ABC, 1'b1, "R10");
        checks++;
        lkp_valid = 1'b1; lkp_la = 32'h1234_5ABC; #1;
        if (lkp_pa !== 40'hAB_CDE0_1ABC) begin
            fails++;
            $display("FAIL R2 pa=%h expected %h", lkp_pa, 40'hAB_CDE0_1ABC);
        end
        lkp_valid = 1'b0;
        fill(32'h0000_7000, 28'h000_0042, 2'd0, 1'b0);
        look(32'h0000_7FFF, 1'b1, "R2");
        look(32'h0000_8000, 1'b0, "R4");
        look(32'h1234_6ABC, 1'b0, "R4");
    endtask

    task automatic t_large();
        fill(32'h4020_0000, 28'h123_47FF, 2'd1, 1'b0);
        look(32'h403F_FFFF, 1'b1, "R3");
        look(32'h4020_1234, 1'b1, "R3");
        look(32'h4040_0000, 1'b0, "R3");
        look(32'h401F_FFFF, 1'b0, "R3");
        fill(32'h8000_0000, 28'hFF0_03FF, 2'd2, 1'b0);
        look(32'h803A_BCDE, 1'b1, "R3");
        look(32'h8040_0000, 1'b0, "R3");
        fill(32'hC000_5000, 28'h000_0777, 2'd3, 1'b0);
        look(32'hC000_5010, 1'b1, "R3");
        look(32'hC000_4010, 1'b0, "R3");
    endtask

    task automatic t_flush();
        glb_enable = 1'b1;
        fill(32'h1111_1000, 28'h000_1111, 2'd0, 1'b1);
        fill(32'h2222_2000, 28'h000_2222, 2'd0, 1'b0);
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
        look(32'h1111_1000, 1'b1, "R6");
        look(32'h2222_2000, 1'b0, "R6");
        fill(32'h2222_2000, 28'h000_2222, 2'd0, 1'b0);
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
        look(32'h1111_1000, 1'b1, "R6");
        look(32'h2222_2000, 1'b0, "R6");
        glb_enable = 1'b0;
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
        look(32'h1111_1000, 1'b0, "R7");
        look(32'h4020_0000, 1'b0, "R7");
        glb_enable = 1'b1;
    endtask

    task automatic t_inval();
        fill(32'h3333_3000, 28'h000_3333, 2'd0, 1'b1);
        fill(32'h4444_4000, 28'h000_4444, 2'd0, 1'b0);
        fill(32'h6000_0000, 28'h000_6000, 2'd1, 1'b1);
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b1, 32'h3333_3123, 1'b0, 1'b0);
        look(32'h3333_3000, 1'b0, "R8");
        look(32'h4444_4000, 1'b1, "R8");
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b1, 32'h601F_F000, 1'b0, 1'b0);
        look(32'h6000_0000, 1'b0, "R8");
        look(32'h4444_4FFF, 1'b1, "R8");
    endtask

    task automatic t_replace();
        glb_enable = 1'b0;
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
        glb_enable = 1'b1;
        for (int i = 0; i < N; i++) fill(32'h0010_0000 + (i << 12), 28'(i + 1), 2'd0, 1'b0);
        look(32'h0010_7000, 1'b1, "R5");
        fill(32'h0020_0000, 28'h000_0200, 2'd0, 1'b0);
        look(32'h0010_0000, 1'b0, "R5");
        look(32'h0020_0000, 1'b1, "R5");
        look(32'h0010_1000, 1'b1, "R5");
        fill(32'h0020_1000, 28'h000_0201, 2'd0, 1'b0);
        look(32'h0010_1000, 1'b0, "R5");
        op(1'b0, '0, '0, 2'd0, 1'b0, 1'b1, 32'h0010_4000, 1'b0, 1'b0);
        fill(32'h0020_2000, 28'h000_0202, 2'd0, 1'b0);
        look(32'h0010_2000, 1'b1, "R5");
        fill(32'h0020_3000, 28'h000_0203, 2'd0, 1'b0);
        look(32'h0010_2000, 1'b0, "R5");
        look(32'h0020_2000, 1'b1, "R5");
        look(32'h0010_3000, 1'b1, "R5");
    endtask

    task automatic t_same_cycle();
        glb_enable = 1'b1;
        fill(32'h5555_5000, 28'h000_5555, 2'd0, 1'b1);
        fill(32'h6666_6000, 28'h000_6666, 2'd0, 1'b0);
        // R9: flush and lookup together; the model is flushed before comparing
        dbase_reload = 1'b1;
        m_flush();
        look(32'h6666_6000, 1'b0, "R9");
        @(negedge clk);
        dbase_reload = 1'b0;
        fill(32'h6666_6000, 28'h000_6666, 2'd0, 1'b0);
        task_switch = 1'b1;
        m_flush();
        look(32'h5555_5000, 1'b1, "R9");
        @(negedge clk);
        task_switch = 1'b0;
        look(32'h6666_6000, 1'b0, "R9");
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_small();
        t_large();
        t_flush();
        t_inval();
        t_replace();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule